// File: doc/BRIEF.md
# Register-Driven Multiply/Divide Unit

The unit is a small arithmetic peripheral. It computes the unsigned product of two bytes and the unsigned quotient and remainder of a 16-bit dividend over an 8-bit divisor. A processor loads operands through a byte-wide register-select port. Two of these writes launch work: the write of the second multiply factor and the write of the divisor. Each operation then runs one step per clock, on a shift-add datapath for the multiply and a restoring-subtract datapath for the divide.

Results are read back combinationally through the same select lines. The quotient has a register pair of its own. A second pair is shared: it shows the product when the most recent launch was a multiply and the remainder when it was a divide. Both pairs update on every step, so a read taken mid-run returns partial values. A `busy_o` flag lets the caller wait for completion. A new launch always wins over a run in progress.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, busy_o is 0 and the quotient and shared result pairs both read 0x0000.
- R2: Write select codes are 0 for factor A, 1 for factor B (launches a multiply), 2 for the dividend low byte, 3 for the dividend high byte and 4 for the divisor (launches a divide). Read select codes are 0/1 for quotient low/high and 2/3 for result low/high. Any other read code returns 0x00.
- R3: When a multiply completes, the result pair holds A*B as a 16-bit unsigned value.
- R4: busy_o rises in the cycle after the factor B write and stays high for exactly 8 cycles.
- R5: When a divide completes with a nonzero divisor, the quotient pair holds dividend/divisor and the result pair holds dividend mod divisor.
- R6: busy_o stays high for exactly 16 cycles after a divisor write.
- R7: A zero divisor yields a quotient of 0xFFFF and a remainder equal to the dividend, with the normal 16-cycle latency.
- R8: A launch write during a running operation of either kind abandons that run. It restarts with the new operands, with full latency counted from the new write. busy_o never rises without a launch write.
- R9: Operand writes of factor A or dividend bytes during a run do not change the running result. They take effect at the next launch.
- R10: During a multiply, after k steps the result pair holds A times the low k bits of B (0x00FF after 1 step and 0x02FD after 2 steps for 0xFF*0xFF).
- R11: A multiply leaves the quotient pair unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the selected register |
| sel_i | input | 3 | Register select for writes and reads |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for sel_i, combinational |
| busy_o | output | 1 | An operation is in progress |

## Verification
The hardest situations to reach are the cross-kind aborts: a divide cut off by a multiply launch, and a multiply cut off by a divide launch. The shared result pair must then switch source, and the latency must restart from the new write. The stimulus stages the dividend before a multiply starts, so the divisor write can land a few cycles into that run. It also starts a divide and launches a multiply partway through. Mid-run operand writes and mid-run reads are timed on exact cycle counts after a launch, which reaches the staging and partial-result behaviour.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int unsigned SEL_W = 3;

  localparam logic [SEL_W-1:0] W_FAC_A  = 3'd0;
  localparam logic [SEL_W-1:0] W_FAC_B  = 3'd1;
  localparam logic [SEL_W-1:0] W_DVD_LO = 3'd2;
  localparam logic [SEL_W-1:0] W_DVD_HI = 3'd3;
  localparam logic [SEL_W-1:0] W_DVSR   = 3'd4;

  localparam logic [SEL_W-1:0] R_QUO_LO = 3'd0;
  localparam logic [SEL_W-1:0] R_QUO_HI = 3'd1;
  localparam logic [SEL_W-1:0] R_RES_LO = 3'd2;
  localparam logic [SEL_W-1:0] R_RES_HI = 3'd3;
endpackage

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter int unsigned OP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [OP_W-1:0]   fac_a_i,
  input  logic [OP_W-1:0]   fac_b_i,
  output logic              busy_o,
  output logic [2*OP_W-1:0] prod_o
);
  localparam int unsigned RES_W = 2 * OP_W;
  localparam int unsigned CNT_W = $clog2(OP_W + 1);

  logic [RES_W-1:0] acc_q, mcand_q;
  logic [OP_W-1:0]  mplier_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
    end else if (start_i) begin
      acc_q    <= '0;
      mcand_q  <= {{OP_W{1'b0}}, fac_a_i};
      mplier_q <= fac_b_i;
      cnt_q    <= CNT_W'(OP_W);
    end else if (abort_i) begin
      cnt_q    <= '0;
    end else if (cnt_q != '0) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      cnt_q    <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);
  assign prod_o = acc_q;
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter int unsigned OP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [2*OP_W-1:0] dvd_i,
  input  logic [OP_W-1:0]   dvsr_i,
  output logic              busy_o,
  output logic [2*OP_W-1:0] quot_o,
  output logic [2*OP_W-1:0] rem_o
);
  localparam int unsigned QW    = 2 * OP_W;
  localparam int unsigned CNT_W = $clog2(QW + 1);

  logic [QW-1:0]    quot_q, dvd_cap_q;
  logic [OP_W-1:0]  prem_q, dvsr_q;
  logic             zero_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OP_W:0]    trial, diff;
  logic             take;

  // restoring step: borrow out of diff means trial < divisor
  assign trial = {prem_q, quot_q[QW-1]};
  assign diff  = trial - {1'b0, dvsr_q};
  assign take  = ~diff[OP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q    <= '0;
      dvd_cap_q <= '0;
      prem_q    <= '0;
      dvsr_q    <= '0;
      zero_q    <= 1'b0;
      cnt_q     <= '0;
    end else if (start_i) begin
      dvd_cap_q <= dvd_i;
      dvsr_q    <= dvsr_i;
      prem_q    <= '0;
      zero_q    <= (dvsr_i == '0);
      quot_q    <= (dvsr_i == '0) ? {QW{1'b1}} : dvd_i;
      cnt_q     <= CNT_W'(QW);
    end else if (abort_i) begin
      cnt_q     <= '0;
    end else if (cnt_q != '0) begin
      if (!zero_q) begin
        prem_q <= take ? diff[OP_W-1:0] : trial[OP_W-1:0];
        quot_q <= {quot_q[QW-2:0], take};
      end
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);
  assign quot_o = quot_q;
  assign rem_o  = zero_q ? dvd_cap_q : {{OP_W{1'b0}}, prem_q};
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [OP_W-1:0]  wdata_i,
  output logic [OP_W-1:0]  rdata_o,
  output logic             busy_o
);
  localparam int unsigned RES_W = 2 * OP_W;

  logic [OP_W-1:0]  fac_a_q;
  logic [RES_W-1:0] dvd_q;
  logic             last_mul_q;
  logic             start_mul, start_div;
  logic             mul_busy, div_busy;
  logic [RES_W-1:0] prod_w, quot_w, rem_w, res_w;

  assign start_mul = wr_i && (sel_i == W_FAC_B);
  assign start_div = wr_i && (sel_i == W_DVSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fac_a_q    <= '0;
      dvd_q      <= '0;
      last_mul_q <= 1'b0;
    end else begin
      if (wr_i && sel_i == W_FAC_A)  fac_a_q            <= wdata_i;
      if (wr_i && sel_i == W_DVD_LO) dvd_q[OP_W-1:0]    <= wdata_i;
      if (wr_i && sel_i == W_DVD_HI) dvd_q[RES_W-1:OP_W] <= wdata_i;
      if (start_mul)      last_mul_q <= 1'b1;
      else if (start_div) last_mul_q <= 1'b0;
    end
  end

  muldiv_mul_core #(.OP_W(OP_W)) mul_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_mul),
    .abort_i (start_div),
    .fac_a_i (fac_a_q),
    .fac_b_i (wdata_i),
    .busy_o  (mul_busy),
    .prod_o  (prod_w)
  );

  muldiv_div_core #(.OP_W(OP_W)) div_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_div),
    .abort_i (start_mul),
    .dvd_i   (dvd_q),
    .dvsr_i  (wdata_i),
    .busy_o  (div_busy),
    .quot_o  (quot_w),
    .rem_o   (rem_w)
  );

  assign res_w  = last_mul_q ? prod_w : rem_w;
  assign busy_o = mul_busy | div_busy;

  always_comb begin
    unique case (sel_i)
      R_QUO_LO: rdata_o = quot_w[OP_W-1:0];
      R_QUO_HI: rdata_o = quot_w[RES_W-1:OP_W];
      R_RES_LO: rdata_o = res_w[OP_W-1:0];
      R_RES_HI: rdata_o = res_w[RES_W-1:OP_W];
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [OP_W-1:0]   wdata_i,
  input logic              busy_o,
  input logic [OP_W-1:0]   fac_a_i,
  input logic [2*OP_W-1:0] dvd_i,
  input logic [2*OP_W-1:0] quot_i,
  input logic [2*OP_W-1:0] res_i
);
  localparam int unsigned RES_W = 2 * OP_W;
  localparam int unsigned CW    = $clog2(RES_W + 1) + 1;

  logic s_mul, s_div, s_any;
  logic kind_mul_q;
  logic [OP_W-1:0]  a_q, b_q, d_q;
  logic [RES_W-1:0] n_q;
  logic [CW-1:0]    run_q;

  assign s_mul = wr_i && (sel_i == W_FAC_B);
  assign s_div = wr_i && (sel_i == W_DVSR);
  assign s_any = s_mul | s_div;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_mul_q <= 1'b0;
      a_q <= '0; b_q <= '0; d_q <= '0; n_q <= '0;
      run_q <= '0;
    end else if (s_any) begin
      kind_mul_q <= s_mul;
      run_q      <= '0;
      if (s_mul) begin a_q <= fac_a_i; b_q <= wdata_i; end
      else       begin n_q <= dvd_i;   d_q <= wdata_i; end
    end else if (busy_o) begin
      run_q <= run_q + CW'(1);
    end
  end

  a_r4_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_any |=> busy_o);

  a_r6_run_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == (kind_mul_q ? CW'(OP_W) : CW'(RES_W)));

  a_r8_no_spurious_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(s_any));

  a_r3_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && kind_mul_q) |->
      res_i == ({{OP_W{1'b0}}, a_q} * {{OP_W{1'b0}}, b_q}));

  a_r5_quot_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !kind_mul_q && d_q != '0) |->
      (quot_i == n_q / {{OP_W{1'b0}}, d_q}) && (res_i == n_q % {{OP_W{1'b0}}, d_q}));

  a_r7_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !kind_mul_q && d_q == '0) |->
      (quot_i == {RES_W{1'b1}}) && (res_i == n_q));
endmodule

bind muldiv_unit muldiv_unit_chk #(.OP_W(OP_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .sel_i   (sel_i),
  .wdata_i (wdata_i),
  .busy_o  (busy_o),
  .fac_a_i (fac_a_q),
  .dvd_i   (dvd_q),
  .quot_i  (quot_w),
  .res_i   (res_w)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       busy_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  muldiv_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_i(sel_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o)
  );

  // {is_div, x(A in low byte or dividend), y(B or divisor), exp_quot, exp_res}
  localparam int NV = 9;
  localparam logic [56:0] VEC [NV] = '{
    {1'b0, 16'h0000, 8'h55, 16'h0000, 16'h0000},
    {1'b0, 16'h00FF, 8'hFF, 16'h0000, 16'hFE01},
    {1'b0, 16'h0012, 8'h34, 16'h0000, 16'h03A8},
    {1'b0, 16'h0080, 8'h02, 16'h0000, 16'h0100},
    {1'b1, 16'hFFFF, 8'h01, 16'hFFFF, 16'h0000},
    {1'b1, 16'h03E8, 8'h07, 16'h008E, 16'h0006},
    {1'b1, 16'h1234, 8'hFF, 16'h0012, 16'h0046},
    {1'b1, 16'h0005, 8'hC8, 16'h0000, 16'h0005},
    {1'b1, 16'hABCD, 8'h00, 16'hFFFF, 16'hABCD}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_i = 1'b1; sel_i = s; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] lo_sel, output logic [15:0] v);
    sel_i = lo_sel;       #1 v[7:0]  = rdata_o;
    sel_i = lo_sel + 3'd1; #1 v[15:8] = rdata_o;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (busy_o && n < 100) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    rd16(3'd0, v); check("R1 quot", {16'd0, v}, 32'h0);
    rd16(3'd2, v); check("R1 res", {16'd0, v}, 32'h0);
    sel_i = 3'd6; #1 check("R2 unused read code", {24'd0, rdata_o}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [56:0] e;
      e = VEC[i];
      if (e[56]) begin
        wr(3'd2, e[47:40]); wr(3'd3, e[55:48]); wr(3'd4, e[39:32]);
        wait_done(n);
        check("R6 div latency", n, 16);
        rd16(3'd0, v); check(e[39:32] == 8'h00 ? "R7 zero quot" : "R5 quot", {16'd0, v}, {16'd0, e[31:16]});
        rd16(3'd2, v); check(e[39:32] == 8'h00 ? "R7 zero rem" : "R5 rem", {16'd0, v}, {16'd0, e[15:0]});
      end else begin
        wr(3'd0, e[47:40]); wr(3'd1, e[39:32]);
        wait_done(n);
        check("R4 mul latency", n, 8);
        rd16(3'd2, v); check("R3 product", {16'd0, v}, {16'd0, e[15:0]});
      end
    end

    // R11: multiply leaves quotient alone
    wr(3'd2, 8'hE8); wr(3'd3, 8'h03); wr(3'd4, 8'h07); wait_done(n);
    wr(3'd0, 8'h03); wr(3'd1, 8'h05); wait_done(n);
    rd16(3'd0, v); check("R11 quot kept", {16'd0, v}, 32'h008E);
    rd16(3'd2, v); check("R11 res is product", {16'd0, v}, 32'h000F);

    // R10: partial products
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    @(negedge clk_i); rd16(3'd2, v); check("R10 step1", {16'd0, v}, 32'h00FF);
    @(negedge clk_i); rd16(3'd2, v); check("R10 step2", {16'd0, v}, 32'h02FD);
    wait_done(n); rd16(3'd2, v); check("R10 final", {16'd0, v}, 32'hFE01);

    // R9: staged operand writes during a run
    wr(3'd0, 8'h10); wr(3'd1, 8'h10);
    wr(3'd0, 8'h77); wr(3'd2, 8'h99);
    wait_done(n); rd16(3'd2, v); check("R9 run unaffected", {16'd0, v}, 32'h0100);
    wr(3'd1, 8'h01); wait_done(n);
    rd16(3'd2, v); check("R9 staged A used next", {16'd0, v}, 32'h0077);

    // R8: mul restarted by mul
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); repeat (3) @(negedge clk_i);
    wr(3'd1, 8'h02); wait_done(n);
    check("R8 mul restart latency", n, 8);
    rd16(3'd2, v); check("R8 mul restart result", {16'd0, v}, 32'h01FE);

    // R8: div aborted by mul
    wr(3'd2, 8'h00); wr(3'd3, 8'h80); wr(3'd4, 8'h03); repeat (4) @(negedge clk_i);
    wr(3'd1, 8'h03); wait_done(n);
    check("R8 div->mul latency", n, 8);
    rd16(3'd2, v); check("R8 div->mul result", {16'd0, v}, 32'h02FD);

    // R8: mul aborted by div, dividend staged first
    wr(3'd2, 8'hE8); wr(3'd3, 8'h03);
    wr(3'd1, 8'hFF); repeat (2) @(negedge clk_i);
    wr(3'd4, 8'h07); wait_done(n);
    check("R8 mul->div latency", n, 16);
    rd16(3'd0, v); check("R8 mul->div quot", {16'd0, v}, 32'h008E);
    rd16(3'd2, v); check("R8 mul->div rem", {16'd0, v}, 32'h0006);

    // R8: idle stays idle without a launch
    wr(3'd0, 8'h12); @(negedge clk_i);
    check("R8 no launch no busy", {31'd0, busy_o}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule